// File: doc/BRIEF.md
# Low-Power Comparator Task and Event Controller

This block is the digital control shell around an analog low-power comparator. Software writes a small configuration set: the positive-input channel, the reference choice (an internal supply-fraction tap or an external pin), the external pin choice, hysteresis and the wake direction. It then enables the block. The block drives the analog multiplexer selects and the hysteresis enable from that configuration. It accepts START, STOP and SAMPLE task strobes.

After an accepted START, the block waits a fixed warm-up interval and then pulses a ready event. From that point on, it watches the comparator's raw output through a synchroniser. It turns each transition into a directional single-cycle event, UP or DOWN, together with a shared CROSS event. It also raises a wake request for a power controller when the crossing matches the chosen direction. A SAMPLE task captures the present comparator level into a result bit.

Top module: `cmp_evt_ctrl`

## Requirements
- R1: After reset, running_o, wake_o, result_o, hyst_en_o and all event outputs are 0, and ain_sel_o and ref_code_o are 0.
- R2: A START that is accepted leads to ev_ready_o high for exactly one cycle, STARTUP_CYC clock edges after the edge that samples START. running_o is high from that edge onward.
- R3: No UP, DOWN or CROSS event fires before the ready pulse. A level that the comparator already held during warm-up produces no event once the block is running.
- R4: While the block is running, a low-to-high change of core_out_i raises ev_up_o and ev_cross_o together for one cycle. They appear after the third clock edge following the change: two synchroniser stages and one event register.
- R5: While the block is running, a high-to-low change of core_out_i raises ev_down_o and ev_cross_o together for one cycle, with the same latency as R4.
- R6: A write with cfg_wr_i high updates one field at the next edge, chosen by cfg_sel_i. The codes are: 0 input channel, 1 reference code, 2 external pin, 3 hysteresis, 4 enable, 5 wake direction. For the reference code, 0 to 14 select the tap at (code+1)/16 of the supply and 15 selects the external reference.
- R7: While enable is set, writes to fields 0, 1, 2, 3 and 5 are ignored and their outputs hold their values. The enable field stays writable at all times.
- R8: A SAMPLE while running copies the synchronised comparator level into result_o at the next edge. Otherwise result_o holds its value.
- R9: A START is refused, with no ready pulse and no running state, while other_busy_i is high or enable is clear.
- R10: A STOP, or clearing enable, returns the block to idle and suppresses all further events. running_o falls at the edge that samples STOP. A START in the same cycle as a STOP is ignored.
- R11: wake_o is set by a crossing in the chosen direction (0 either, 1 up, 2 down) and appears with that crossing's event. It is cleared by a wake_ack_i pulse or by leaving the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Field code for the write |
| cfg_wdata_i | input | 4 | Write data, LSB-aligned |
| task_start_i | input | 1 | START task strobe |
| task_stop_i | input | 1 | STOP task strobe |
| task_sample_i | input | 1 | SAMPLE task strobe |
| other_busy_i | input | 1 | Other comparator is active |
| core_out_i | input | 1 | Raw comparator output (asynchronous) |
| wake_ack_i | input | 1 | Clears the wake request |
| ain_sel_o | output | 3 | Positive-input channel select |
| ref_code_o | output | 4 | Reference tap code, 15 means external |
| ext_pin_o | output | 1 | External reference pin choice |
| hyst_en_o | output | 1 | Hysteresis enable to the core |
| enabled_o | output | 1 | Enable field |
| running_o | output | 1 | Warm-up complete and block active |
| ev_ready_o | output | 1 | Ready event |
| ev_up_o | output | 1 | Upward crossing event |
| ev_down_o | output | 1 | Downward crossing event |
| ev_cross_o | output | 1 | Any crossing event |
| result_o | output | 1 | Sampled comparator level |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
Each result has a fixed latency. The ready pulse is due STARTUP_CYC edges after the START edge. Crossing events and the wake request are due three edges after core_out_i moves. Configuration fields, result_o and the running flag after STOP are due one edge after their strobe.

The driver records the stimulus cycle from a free-running cycle counter and queues each expected event with its exact due cycle. The monitor compares every cycle on the falling clock edge, so an early, late, missing or extra event is reported. Level outputs are checked directly on the falling edge right after their due edge.

// File: rtl/cmp_evt_pkg.sv
// Package: shared field codes and state encodings for the comparator controller.
// Assumes: software uses the codes below on the configuration write port.
package cmp_evt_pkg;

    typedef enum logic [2:0] {
        FLD_AIN     = 3'd0,
        FLD_REF     = 3'd1,
        FLD_EXTPIN  = 3'd2,
        FLD_HYST    = 3'd3,
        FLD_ENABLE  = 3'd4,
        FLD_WAKEDIR = 3'd5
    } cfg_field_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WARM = 2'd1,
        ST_RUN  = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        WK_CROSS = 2'd0,
        WK_UP    = 2'd1,
        WK_DOWN  = 2'd2
    } wake_dir_e;

endpackage

// File: rtl/cmp_evt_cfg.sv
// Configuration register file. Holds the mux selects, hysteresis, enable and
// wake direction. Assumes DATA_W covers the widest field. Every field except
// enable is locked while enable is set.
module cmp_evt_cfg
    import cmp_evt_pkg::*;
#(
    parameter int AIN_W  = 3,
    parameter int REF_W  = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [AIN_W-1:0]  ain_sel,
    output logic [REF_W-1:0]  ref_code,
    output logic              ext_pin,
    output logic              hyst_en,
    output logic              enable,
    output wake_dir_e         wake_dir
);

    logic locked;
    assign locked = enable;

    // Field update: enable always writable, the rest only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ain_sel  <= '0;
            ref_code <= '0;
            ext_pin  <= 1'b0;
            hyst_en  <= 1'b0;
            enable   <= 1'b0;
            wake_dir <= WK_CROSS;
        end else if (wr) begin
            case (cfg_field_e'(sel))
                FLD_ENABLE:  enable <= wdata[0];
                FLD_AIN:     if (!locked) ain_sel  <= wdata[AIN_W-1:0];
                FLD_REF:     if (!locked) ref_code <= wdata[REF_W-1:0];
                FLD_EXTPIN:  if (!locked) ext_pin  <= wdata[0];
                FLD_HYST:    if (!locked) hyst_en  <= wdata[0];
                FLD_WAKEDIR: if (!locked) wake_dir <= wake_dir_e'(wdata[1:0]);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cmp_evt_sync.sv
// Multi-stage synchroniser for the asynchronous comparator output.
// Assumes STAGES >= 2. The output lags the input by STAGES edges.
module cmp_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the raw level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= d;
            end
        end else begin : g_next
            // Later stages shift the level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/cmp_evt_seq.sv
// Run sequencer: idle, warm-up and run states, a warm-up counter and the
// ready pulse. Assumes STARTUP_CYC >= 1. STOP or a cleared enable forces idle
// and outranks START.
module cmp_evt_seq
    import cmp_evt_pkg::*;
#(
    parameter int STARTUP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start,
    input  logic stop,
    input  logic other_busy,
    output logic running,
    output logic halt,
    output logic ready_pulse
);

    localparam int CNT_W = $clog2(STARTUP_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STARTUP_CYC - 1);

    run_state_e state;
    logic [CNT_W-1:0] cnt;

    assign halt    = stop || !enable;
    assign running = (state == ST_RUN);

    // State, warm-up count and ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            ready_pulse <= 1'b0;
        end else begin
            ready_pulse <= 1'b0;
            if (halt) begin
                state <= ST_IDLE;
                cnt   <= '0;
            end else begin
                case (state)
                    ST_IDLE: if (start && !other_busy) begin
                        state <= ST_WARM;
                        cnt   <= '0;
                    end
                    ST_WARM: if (cnt == LAST) begin
                        state       <= ST_RUN;
                        ready_pulse <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmp_evt_edge.sv
// Edge events, wake request and sample register. The previous-level register
// tracks the synchronised level in every state, so warm-up preloads the baseline.
// Events fire only while running and not halted.
module cmp_evt_edge
    import cmp_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  logic      running,
    input  logic      halt,
    input  wake_dir_e wake_dir,
    input  logic      wake_ack,
    input  logic      sample,
    output logic      ev_up,
    output logic      ev_down,
    output logic      ev_cross,
    output logic      wake,
    output logic      result
);

    logic prev;
    logic fire_ok, rise, fall, hit;

    assign fire_ok = running && !halt;
    assign rise    = lvl && !prev;
    assign fall    = !lvl && prev;

    // Select whether this crossing matches the wake direction.
    always_comb begin
        case (wake_dir)
            WK_UP:   hit = rise;
            WK_DOWN: hit = fall;
            default: hit = rise || fall;
        endcase
    end

    // Previous level and registered single-cycle events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev     <= 1'b0;
            ev_up    <= 1'b0;
            ev_down  <= 1'b0;
            ev_cross <= 1'b0;
        end else begin
            prev     <= lvl;
            ev_up    <= fire_ok && rise;
            ev_down  <= fire_ok && fall;
            ev_cross <= fire_ok && (rise || fall);
        end
    end

    // Wake request: set on a matching crossing, cleared by ack or leaving run.
    always_ff @(posedge clk) begin
        if (!rst_n)          wake <= 1'b0;
        else if (!fire_ok)   wake <= 1'b0;
        else if (hit)        wake <= 1'b1;
        else if (wake_ack)   wake <= 1'b0;
    end

    // Sample register: captures the level on SAMPLE while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                 result <= 1'b0;
        else if (sample && running) result <= lvl;
    end

endmodule

// File: rtl/cmp_evt_ctrl.sv
// Top of the comparator task and event controller. Ties the configuration file,
// synchroniser, run sequencer and edge logic together. Assumes the analog core
// output is asynchronous and the task strobes are single-cycle.
module cmp_evt_ctrl
    import cmp_evt_pkg::*;
#(
    parameter int AIN_W       = 3,
    parameter int REF_W       = 4,
    parameter int DATA_W      = 4,
    parameter int STARTUP_CYC = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    input  logic              task_start_i,
    input  logic              task_stop_i,
    input  logic              task_sample_i,
    input  logic              other_busy_i,
    input  logic              core_out_i,
    input  logic              wake_ack_i,
    output logic [AIN_W-1:0]  ain_sel_o,
    output logic [REF_W-1:0]  ref_code_o,
    output logic              ext_pin_o,
    output logic              hyst_en_o,
    output logic              enabled_o,
    output logic              running_o,
    output logic              ev_ready_o,
    output logic              ev_up_o,
    output logic              ev_down_o,
    output logic              ev_cross_o,
    output logic              result_o,
    output logic              wake_o
);

    wake_dir_e wake_dir;
    logic      lvl_sync;
    logic      halt;

    cmp_evt_cfg #(.AIN_W(AIN_W), .REF_W(REF_W), .DATA_W(DATA_W)) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr_i),
        .sel      (cfg_sel_i),
        .wdata    (cfg_wdata_i),
        .ain_sel  (ain_sel_o),
        .ref_code (ref_code_o),
        .ext_pin  (ext_pin_o),
        .hyst_en  (hyst_en_o),
        .enable   (enabled_o),
        .wake_dir (wake_dir)
    );

    cmp_evt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (core_out_i),
        .q     (lvl_sync)
    );

    cmp_evt_seq #(.STARTUP_CYC(STARTUP_CYC)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enabled_o),
        .start       (task_start_i),
        .stop        (task_stop_i),
        .other_busy  (other_busy_i),
        .running     (running_o),
        .halt        (halt),
        .ready_pulse (ev_ready_o)
    );

    cmp_evt_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_sync),
        .running  (running_o),
        .halt     (halt),
        .wake_dir (wake_dir),
        .wake_ack (wake_ack_i),
        .sample   (task_sample_i),
        .ev_up    (ev_up_o),
        .ev_down  (ev_down_o),
        .ev_cross (ev_cross_o),
        .wake     (wake_o),
        .result   (result_o)
    );

endmodule

// File: rtl/cmp_evt_chk.sv
// Checker for cmp_evt_ctrl, attached by bind. Watches only top-level ports.
module cmp_evt_chk #(
    parameter int AIN_W = 3,
    parameter int REF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             task_sample_i,
    input logic [AIN_W-1:0] ain_sel_o,
    input logic [REF_W-1:0] ref_code_o,
    input logic             hyst_en_o,
    input logic             enabled_o,
    input logic             running_o,
    input logic             ev_ready_o,
    input logic             ev_up_o,
    input logic             ev_down_o,
    input logic             ev_cross_o,
    input logic             result_o,
    input logic             wake_o
);

    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ready_o |=> !ev_ready_o);

    assert_evt_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_up_o || ev_down_o || ev_cross_o) |-> $past(running_o));

    assert_up_with_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_up_o |-> ev_cross_o);

    assert_down_with_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_down_o |-> (ev_cross_o && !ev_up_o));

    assert_cfg_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled_o && $past(enabled_o)) |-> ($stable(ain_sel_o) && $stable(ref_code_o) && $stable(hyst_en_o)));

    assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(task_sample_i) |-> $stable(result_o));

    assert_wake_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> running_o);

endmodule

bind cmp_evt_ctrl cmp_evt_chk #(.AIN_W(AIN_W), .REF_W(REF_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .task_sample_i (task_sample_i),
    .ain_sel_o     (ain_sel_o),
    .ref_code_o    (ref_code_o),
    .hyst_en_o     (hyst_en_o),
    .enabled_o     (enabled_o),
    .running_o     (running_o),
    .ev_ready_o    (ev_ready_o),
    .ev_up_o       (ev_up_o),
    .ev_down_o     (ev_down_o),
    .ev_cross_o    (ev_cross_o),
    .result_o      (result_o),
    .wake_o        (wake_o)
);

// File: tb/cmp_evt_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected events with due cycles, and the
// monitor compares them on every falling edge.
module cmp_evt_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SU = 16;
    localparam logic [3:0] M_READY = 4'b1000;
    localparam logic [3:0] M_UP    = 4'b0101;
    localparam logic [3:0] M_DOWN  = 4'b0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [3:0] cfg_wdata = '0;
    logic t_start = 1'b0, t_stop = 1'b0, t_sample = 1'b0;
    logic busy = 1'b0, core = 1'b0, ack = 1'b0;
    logic [2:0] ain_sel;
    logic [3:0] ref_code;
    logic ext_pin, hyst_en, enabled, running;
    logic ev_ready, ev_up, ev_down, ev_cross, result, wake;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    int stray = 0;

    typedef struct {
        int         due;
        logic [3:0] mask;
        string      tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmp_evt_ctrl #(.STARTUP_CYC(SU)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .task_start_i(t_start), .task_stop_i(t_stop),
        .task_sample_i(t_sample), .other_busy_i(busy), .core_out_i(core),
        .wake_ack_i(ack), .ain_sel_o(ain_sel), .ref_code_o(ref_code),
        .ext_pin_o(ext_pin), .hyst_en_o(hyst_en), .enabled_o(enabled),
        .running_o(running), .ev_ready_o(ev_ready), .ev_up_o(ev_up),
        .ev_down_o(ev_down), .ev_cross_o(ev_cross), .result_o(result),
        .wake_o(wake)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input int sel, input int data);
        cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = 4'(data);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push(input int due, input logic [3:0] mask, input string tag);
        exp_t x;
        x.due = due; x.mask = mask; x.tag = tag;
        q.push_back(x);
    endtask

    // Accepted START: ready due SU edges after the sampling edge.
    task automatic start_ok();
        push(cyc + SU + 1, M_READY, "R2");
        t_start = 1'b1;
        @(negedge clk);
        t_start = 1'b0;
    endtask

    // Core move: event due three edges later.
    task automatic move_core(input logic v, input string tag);
        push(cyc + 3, v ? M_UP : M_DOWN, tag);
        core = v;
    endtask

    task automatic pulse_stop();
        t_stop = 1'b1; @(negedge clk); t_stop = 1'b0;
    endtask

    task automatic pulse_sample();
        t_sample = 1'b1; @(negedge clk); t_sample = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: compare event outputs against the queue on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && q[0].due <= cyc) begin
                e = q.pop_front();
                total++;
                if (e.due != cyc || {ev_ready, ev_up, ev_down, ev_cross} != e.mask) begin
                    bad++;
                    $display("FAIL %s: actual=%b expected=%b due=%0d at cycle %0d",
                             e.tag, {ev_ready, ev_up, ev_down, ev_cross}, e.mask, e.due, cyc);
                end
            end else if ({ev_ready, ev_up, ev_down, ev_cross} != 4'b0) begin
                total++;
                bad++;
                stray++;
                $display("FAIL R3 or R10 stray event: actual=%b expected=0000 at cycle %0d",
                         {ev_ready, ev_up, ev_down, ev_cross}, cyc);
            end
        end
    end

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 running", running, 0);
        check("R1 wake", wake, 0);
        check("R1 result", result, 0);
        check("R1 hyst", hyst_en, 0);
        check("R1 ain", ain_sel, 0);
        check("R1 ref", ref_code, 0);

        // R6 configuration written while disabled
        write_cfg(0, 5);
        write_cfg(1, 15);
        write_cfg(2, 1);
        write_cfg(3, 1);
        write_cfg(5, 1);
        check("R6 ain", ain_sel, 5);
        check("R6 ref", ref_code, 15);
        check("R6 ext", ext_pin, 1);
        check("R6 hyst", hyst_en, 1);

        // R7 writes ignored while enabled
        write_cfg(4, 1);
        check("R6 enable", enabled, 1);
        write_cfg(0, 2);
        write_cfg(3, 0);
        check("R7 ain held", ain_sel, 5);
        check("R7 hyst held", hyst_en, 1);

        // R9 START refused while the other comparator is busy
        busy = 1'b1;
        t_start = 1'b1; @(negedge clk); t_start = 1'b0;
        wait_n(SU + 4);
        check("R9 running", running, 0);
        busy = 1'b0;

        // R10 START together with STOP ignored
        t_start = 1'b1; t_stop = 1'b1; @(negedge clk);
        t_start = 1'b0; t_stop = 1'b0;
        wait_n(SU + 4);
        check("R10 start+stop running", running, 0);

        // R2 and R3: START, core moves during warm-up give no events
        core = 1'b0;
        start_ok();
        wait_n(3);
        core = 1'b1;
        wait_n(4);
        core = 1'b0;
        wait_n(SU);
        check("R2 running", running, 1);
        check("R3 no warm-up events", stray, 0);

        // R4 rise with wake direction up
        move_core(1'b1, "R4");
        wait_n(4);
        check("R11 wake on up", wake, 1);
        // R8 sample high
        pulse_sample();
        check("R8 result high", result, 1);
        pulse_ack();
        check("R11 ack clears", wake, 0);

        // R5 fall does not wake for direction up
        move_core(1'b0, "R5");
        wait_n(4);
        check("R11 no wake on down", wake, 0);
        pulse_sample();
        check("R8 result low", result, 0);
        move_core(1'b1, "R4");
        wait_n(4);
        check("R8 result holds", result, 0);
        check("R11 wake again", wake, 1);

        // R10 STOP ends running, clears wake, suppresses events
        pulse_stop();
        check("R10 stop running", running, 0);
        check("R10 stop wake", wake, 0);
        core = 1'b0;
        wait_n(5);
        check("R10 no events after stop", stray, 0);

        // R11 direction down, then R10 disable stops the block
        write_cfg(4, 0);
        write_cfg(5, 2);
        write_cfg(4, 1);
        start_ok();
        wait_n(SU + 2);
        move_core(1'b1, "R4");
        wait_n(4);
        check("R11 down dir ignores rise", wake, 0);
        move_core(1'b0, "R5");
        wait_n(4);
        check("R11 down dir wakes on fall", wake, 1);
        write_cfg(4, 0);
        @(negedge clk);
        check("R10 disable running", running, 0);
        check("R10 disable wake", wake, 0);
        wait_n(3);
        check("R2 all expected events seen", q.size(), 0);
        finish_run();
    end

endmodule